// File: doc/BRIEF.md
# Memory Bank Decode and Access Sequencer

This block sits between a 32-bit bus master and a set of memory banks. Each bank has two registers: a base register, which holds the upper address bits and an enable flag, and an option register. The option register holds a compare mask, a flag that holds off the data-buffer strobe, a flag that forbids bursts, and a 2-bit code that sets how long a read must settle before the next access. The block takes each incoming request and compares it against every enabled bank. Only the address bits selected by the bank's mask take part in the compare. The lowest-indexed bank that matches is chosen, and the block then issues the access toward that bank as one or more beats on an output handshake.

A burst request is either passed through as one burst access, or cut into four single accesses at addresses 8 bytes apart. Each of those accesses has its own handshake. After the last beat of a read, the input side stays closed for 0, 1, 4 or 8 idle cycles, as the bank's code sets. A request that matches no bank produces no access and raises a one-cycle flag.

Software programs the banks through a small register port. The port writes in one cycle and reads combinationally. Bank settings are sampled when a request is accepted, so a register change made during an access has no effect on that access.

Top module: `bank_access_seq`

## Requirements
- R1: After reset, every base and option register reads back zero, req_ready is 1, and acc_valid and nomatch are 0.
- R2: The address is compared in bits [31:15]. The mask is in option bits [31:15], the base is in base bits [31:15], and the enable flag is base bit 0. A set mask bit requires that address bit to equal the base bit. A clear mask bit leaves that address bit out of the compare. Any mask pattern, contiguous or not, is accepted.
- R3: When several enabled banks match, the access goes to the lowest-indexed one. acc_bank is the one-hot form of that index.
- R4: A request that matches no enabled bank produces no access. nomatch is 1 for exactly the cycle after acceptance, and req_ready stays 1.
- R5: When option bit 4 (buffer-control disable) is set, acc_bctl stays 0 for that bank's beats. When it is clear, acc_bctl equals acc_valid.
- R6: A burst request to a bank with option bit 3 (burst inhibit) clear produces one access with acc_burst=1 at the request address.
- R7: A burst request to a bank with option bit 3 set produces four accesses, each with acc_burst=0. Their addresses are the request address plus 0, 8, 16 and 24, and each beat completes on its own acc_valid/acc_ready handshake.
- R8: After the final beat of a read, req_ready stays 0 for G cycles. G is 0, 1, 4 or 8 for option bits [1:0] = 00, 01, 10 and 11. After a write, req_ready returns on the cycle after the final beat.
- R9: A register write made while an access is in progress does not change that access. It applies from the next accepted request.
- R10: Reserved register bits are ignored on write and read back as zero. That covers base bits [14:1] and option bits [14:5] and bit 2.
- R11: While acc_valid is 1 and acc_ready is 0, the access outputs hold steady. req_ready is 0 from acceptance until the access, including any gap, is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_kind | input | 1 | 0 selects the base register, 1 selects the option register |
| cfg_sel | input | 2 | Bank index for register access |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_burst | input | 1 | Request is a four-beat burst |
| acc_valid | output | 1 | Access beat valid |
| acc_ready | input | 1 | Beat accepted downstream |
| acc_addr | output | 32 | Beat address |
| acc_write | output | 1 | Beat direction |
| acc_burst | output | 1 | Beat is a full burst access |
| acc_bank | output | 4 | One-hot selected bank |
| acc_bctl | output | 1 | Data-buffer control strobe |
| nomatch | output | 1 | One-cycle pulse when a request matched no bank |

## Verification
A wrong bank index or a wrong latched option shows on the first beat, one cycle after acceptance. It appears as a wrong acc_bank bit, a wrong acc_bctl level, or a wrong acc_burst level. A beat counter that is off by one shows as a missing or extra beat, or as a wrong address on a later beat of a split burst. A bad gap count shows only after the final read beat, as req_ready coming back too early or too late by a counted number of cycles. For that reason, the bench counts the low cycles of req_ready after each read for all four codes.

// File: rtl/bank_access_seq.sv
module bank_access_seq #(
  parameter int NBANK  = 4,
  parameter int AW     = 32,
  parameter int MW     = 17,
  parameter int BEATS  = 4,
  parameter int STRIDE = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_kind,
  input  logic [$clog2(NBANK)-1:0] cfg_sel,
  input  logic [AW-1:0]            cfg_wdata,
  output logic [AW-1:0]            cfg_rdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_write,
  input  logic                     req_burst,
  output logic                     acc_valid,
  input  logic                     acc_ready,
  output logic [AW-1:0]            acc_addr,
  output logic                     acc_write,
  output logic                     acc_burst,
  output logic [NBANK-1:0]         acc_bank,
  output logic                     acc_bctl,
  output logic                     nomatch
);
  localparam int BW  = $clog2(NBANK);
  localparam int LSB = AW - MW;
  localparam int CW  = $clog2(BEATS) + 1;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP} state_t;

  logic [MW-1:0] base_q [NBANK];
  logic [MW-1:0] mask_q [NBANK];
  logic [NBANK-1:0] vld_q, bctld_q, bi_q;
  logic [1:0] hold_q [NBANK];

  state_t        st;
  logic [BW-1:0] bank_q;
  logic [CW-1:0] left_q;
  logic [3:0]    gap_q;
  logic          wr_q, burst_q, bctld_s, nomatch_q;
  logic [1:0]    hold_s;
  logic [AW-1:0] addr_q;

  logic          hit;
  logic [BW-1:0] hit_idx;

  function automatic logic [3:0] gap_len(input logic [1:0] code);
    case (code)
      2'b00:   gap_len = 4'd0;
      2'b01:   gap_len = 4'd1;
      2'b10:   gap_len = 4'd4;
      default: gap_len = 4'd8;
    endcase
  endfunction

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (vld_q[i] && (((req_addr[AW-1:LSB] ^ base_q[i]) & mask_q[i]) == '0)) begin
        hit = 1'b1;
        hit_idx = BW'(i);
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBANK; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        hold_q[i] <= '0;
      end
      vld_q   <= '0;
      bctld_q <= '0;
      bi_q    <= '0;
    end else if (cfg_we) begin
      if (!cfg_kind) begin
        base_q[cfg_sel] <= cfg_wdata[AW-1:LSB];
        vld_q[cfg_sel]  <= cfg_wdata[0];
      end else begin
        mask_q[cfg_sel]  <= cfg_wdata[AW-1:LSB];
        bctld_q[cfg_sel] <= cfg_wdata[4];
        bi_q[cfg_sel]    <= cfg_wdata[3];
        hold_q[cfg_sel]  <= cfg_wdata[1:0];
      end
    end
  end

  assign cfg_rdata = cfg_kind
    ? {mask_q[cfg_sel], {(LSB-5){1'b0}}, bctld_q[cfg_sel], bi_q[cfg_sel], 1'b0, hold_q[cfg_sel]}
    : {base_q[cfg_sel], {(LSB-1){1'b0}}, vld_q[cfg_sel]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bank_q    <= '0;
      left_q    <= '0;
      gap_q     <= '0;
      wr_q      <= 1'b0;
      burst_q   <= 1'b0;
      bctld_s   <= 1'b0;
      hold_s    <= '0;
      addr_q    <= '0;
      nomatch_q <= 1'b0;
    end else begin
      nomatch_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          if (hit) begin
            st      <= S_ACC;
            bank_q  <= hit_idx;
            addr_q  <= req_addr;
            wr_q    <= req_write;
            burst_q <= req_burst & ~bi_q[hit_idx];
            left_q  <= (req_burst && bi_q[hit_idx]) ? CW'(BEATS - 1) : '0;
            bctld_s <= bctld_q[hit_idx];
            hold_s  <= hold_q[hit_idx];
          end else begin
            nomatch_q <= 1'b1;
          end
        end
        S_ACC: if (acc_ready) begin
          if (left_q != '0) begin
            left_q <= left_q - 1'b1;
            addr_q <= addr_q + AW'(STRIDE);
          end else if (!wr_q && gap_len(hold_s) != 4'd0) begin
            st    <= S_GAP;
            gap_q <= gap_len(hold_s);
          end else begin
            st <= S_IDLE;
          end
        end
        default: begin
          if (gap_q <= 4'd1) st <= S_IDLE;
          gap_q <= gap_q - 1'b1;
        end
      endcase
    end
  end

  assign req_ready = (st == S_IDLE);
  assign acc_valid = (st == S_ACC);
  assign acc_addr  = addr_q;
  assign acc_write = wr_q;
  assign acc_burst = burst_q;
  assign acc_bank  = acc_valid ? (NBANK'(1) << bank_q) : '0;
  assign acc_bctl  = acc_valid & ~bctld_s;
  assign nomatch   = nomatch_q;
endmodule

module bank_access_seq_chk #(
  parameter int NBANK = 4,
  parameter int AW    = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             acc_valid,
  input logic             acc_ready,
  input logic [AW-1:0]    acc_addr,
  input logic [NBANK-1:0] acc_bank,
  input logic             acc_bctl,
  input logic             nomatch
);
  AST_BANK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($countones(acc_bank) == 1)); // R3
  AST_NOMATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    nomatch |-> (!acc_valid && req_ready)); // R4
  AST_BCTL_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bctl |-> acc_valid); // R5
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_ready) |=> (acc_valid && $stable(acc_addr) && $stable(acc_bank))); // R11
  AST_BUSY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> !req_ready); // R11
  AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_valid) |-> $past(req_valid && req_ready)); // R11
endmodule

bind bank_access_seq bank_access_seq_chk #(.NBANK(NBANK), .AW(AW)) u_chk (.*);

// File: tb/tb_bank_access_seq.sv
module tb_bank_access_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_kind = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0, cfg_rdata;
  logic req_valid = 0, req_ready, req_write = 0, req_burst = 0;
  logic [31:0] req_addr = 0;
  logic acc_valid, acc_ready = 0, acc_write, acc_burst, acc_bctl, nomatch;
  logic [31:0] acc_addr;
  logic [3:0] acc_bank;

  int checks = 0, errors = 0;
  logic [31:0] sh_base [NB];
  logic [31:0] sh_opt  [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_access_seq dut (.*);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int ref_bank(input logic [31:0] a);
    for (int i = 0; i < NB; i++)
      if (sh_base[i][0] && (((a[31:15] ^ sh_base[i][31:15]) & sh_opt[i][31:15]) == 17'd0))
        return i;
    return -1;
  endfunction

  function automatic int ref_gap(input logic [1:0] c);
    case (c)
      2'b00: return 0;
      2'b01: return 1;
      2'b10: return 4;
      default: return 8;
    endcase
  endfunction

  task automatic wr_cfg(input bit kind, input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_kind = kind; cfg_sel = 2'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (kind) sh_opt[idx] = d & 32'hFFFF_801B;
    else      sh_base[idx] = d & 32'hFFFF_8001;
  endtask

  // full request; optional mid-access option write to bank mid_idx
  task automatic do_req(input logic [31:0] a, input bit wr, input bit bu,
                        input bit mid_wr, input logic [31:0] mid_d);
    int b, nbeat, g, lowc;
    logic [31:0] opt;
    @(negedge clk);
    chk(req_ready == 1, "R11 ready before request", 32'(req_ready), 1);
    b = ref_bank(a);
    opt = (b >= 0) ? sh_opt[b] : 0;
    req_valid = 1; req_addr = a; req_write = wr; req_burst = bu;
    @(negedge clk);
    req_valid = 0;
    if (b < 0) begin
      chk(nomatch == 1 && acc_valid == 0, "R4 miss pulse", {30'd0, nomatch, acc_valid}, 32'h2);
      @(negedge clk);
      chk(nomatch == 0 && req_ready == 1, "R4 pulse one cycle", {30'd0, nomatch, req_ready}, 32'h1);
      return;
    end
    if (mid_wr) begin
      cfg_we = 1; cfg_kind = 1; cfg_sel = 2'(b); cfg_wdata = mid_d;
      @(negedge clk);
      cfg_we = 0;
    end
    nbeat = (bu && opt[3]) ? 4 : 1;
    for (int k = 0; k < nbeat; k++) begin
      int st = int'($urandom_range(0, 2));
      for (int s = 0; s < st; s++) @(negedge clk);
      chk(acc_valid == 1 && req_ready == 0, "R11 beat valid, input closed", {30'd0, acc_valid, req_ready}, 32'h2);
      chk(acc_addr == a + 32'(8 * k), (nbeat == 4) ? "R7 split address" : "R6 access address", acc_addr, a + 32'(8 * k));
      chk(acc_bank == 4'(1 << b), "R3 bank select", 32'(acc_bank), 32'(1 << b));
      chk(acc_bctl == !opt[4], mid_wr ? "R9 old buffer control kept" : "R5 buffer control", 32'(acc_bctl), 32'(!opt[4]));
      chk(acc_burst == (bu && !opt[3]) && acc_write == wr, (nbeat == 4) ? "R7 beat is single" : "R6 burst flag",
          {30'd0, acc_burst, acc_write}, {30'd0, bu && !opt[3], wr});
      acc_ready = 1;
      @(negedge clk);
      acc_ready = 0;
    end
    if (mid_wr) sh_opt[b] = mid_d & 32'hFFFF_801B;
    g = wr ? 0 : ref_gap(opt[1:0]);
    lowc = 0;
    while (!req_ready && lowc < 20) begin
      chk(acc_valid == 0, "R7 no extra beat", 32'(acc_valid), 0);
      lowc++;
      @(negedge clk);
    end
    chk(lowc == g, "R8 idle gap length", 32'(lowc), 32'(g));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NB; i++) begin sh_base[i] = 0; sh_opt[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1 && acc_valid == 0 && nomatch == 0, "R1 reset outputs",
        {29'd0, req_ready, acc_valid, nomatch}, 32'h4);
    for (int i = 0; i < NB; i++)
      for (int k = 0; k < 2; k++) begin
        cfg_sel = 2'(i); cfg_kind = k[0];
        #1 chk(cfg_rdata == 0, "R1 register reset value", cfg_rdata, 0);
      end
    // R4: no bank enabled
    do_req(32'h1234_0000, 0, 0, 0, 0);
    // R10: reserved bits
    wr_cfg(0, 1, 32'hFFFF_FFFF);
    cfg_sel = 1; cfg_kind = 0; #1 chk(cfg_rdata == 32'hFFFF_8001, "R10 base reserved bits", cfg_rdata, 32'hFFFF_8001);
    wr_cfg(1, 1, 32'hFFFF_FFFF);
    cfg_sel = 1; cfg_kind = 1; #1 chk(cfg_rdata == 32'hFFFF_801B, "R10 option reserved bits", cfg_rdata, 32'hFFFF_801B);
    // R2: non-contiguous mask; bank 0 compares only bits 31 and 20
    wr_cfg(0, 1, 0);
    wr_cfg(0, 0, 32'h8000_0001);
    wr_cfg(1, 0, 32'h8010_0000);
    do_req(32'h8000_0000, 1, 0, 0, 0);
    do_req(32'hF00F_0000, 1, 0, 0, 0);
    do_req(32'h8010_0000, 1, 0, 0, 0);
    do_req(32'h0000_0000, 1, 0, 0, 0);
    // R3: bank 2 fully open, bank 0 also matches -> bank 0 wins
    wr_cfg(0, 2, 32'h0000_0001);
    do_req(32'h8000_0000, 0, 0, 0, 0);
    do_req(32'h0000_0000, 0, 0, 0, 0);
    // R6/R7 and R8 for each code
    for (int c = 0; c < 4; c++) begin
      wr_cfg(1, 0, 32'h8000_0000 | 32'(c));
      do_req(32'h8000_0100, 0, 1, 0, 0);
      wr_cfg(1, 0, 32'h8000_0018 | 32'(c));
      do_req(32'h8000_0200, 0, 1, 0, 0);
      do_req(32'h8000_0300, 1, 1, 0, 0);
    end
    // R9: change option mid-access
    wr_cfg(1, 0, 32'h8000_0008);
    do_req(32'h8000_0400, 0, 1, 1, 32'h8000_0013);
    do_req(32'h8000_0500, 0, 1, 0, 0);
    // random mix
    for (int n = 0; n < 300; n++) begin
      logic [31:0] a;
      if ($urandom_range(0, 4) == 0) begin
        int bi = int'($urandom_range(0, 3));
        wr_cfg(0, bi, $urandom());
        wr_cfg(1, bi, $urandom() & 32'hFFFF_FFE3 | (($urandom() & 32'h7) << 0) | (($urandom() & 32'h3) << 3));
      end
      a = sh_base[$urandom_range(0, 3)];
      a = (a ^ ($urandom() & (32'h1 << $urandom_range(15, 31)))) & 32'hFFFF_FFF8;
      a[14:3] = 12'($urandom());
      do_req(a, 1'($urandom()), 1'($urandom()), 0, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule